// File: doc/BRIEF.md
# Token-Paced Cell Leaky Bucket

This block takes bursty cell traffic and turns it into a paced output stream. Arriving cells enter on a valid/ready stream and are kept in an on-chip cell store. A free-running pace timer earns one token each time a fixed interval elapses. The token count is capped at a maximum, which sets the largest burst the block may send after an idle period.

A cell is offered on the output stream only while the store holds a cell and at least one token is available. Each completed output handshake removes one cell and spends one token. When the store is full, input ready drops, so upstream logic holds its cell instead of losing it. After reset the bucket is empty and the timer starts at zero, so the first release waits a full interval.

Top module: `cell_pacer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The token count and the pace timer start at zero, so a cell accepted on the first clock edge after reset leaves no earlier than rising edge PACE+1, counting the first edge after reset release as edge 1.
- R2: Cells leave in the order they were accepted, and none is lost or duplicated.
- R3: While DEPTH cells are stored, `in_ready` is 0. A cell offered at that time is held off and accepted once space frees up.
- R4: One token is earned on every PACE-th edge after reset release. With a backlog and no spare tokens, successive releases are exactly PACE cycles apart.
- R5: `out_valid` is 1 exactly when the store is non-empty and the token count is above zero.
- R6: The token count never exceeds MAX_TOKENS, and a token earned at the cap is discarded. After a long idle period with the output stalled, exactly MAX_TOKENS cells leave back to back before pacing resumes.
- R7: A cell is removed, and one token spent, only on a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: When a token is earned and one is spent on the same edge, the token count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cell offered |
| in_ready | output | 1 | Store can accept a cell |
| in_data | input | CELL_W | Input cell payload |
| out_valid | output | 1 | A cell is released and waiting |
| out_ready | input | 1 | Downstream takes the cell |
| out_data | output | CELL_W | Released cell payload |

## Verification
A wrong token count shows at the output within one pace interval. It appears as a release one cycle too early or too late, or as a burst after idle that is longer or shorter than the cap. A pointer or occupancy error in the cell store shows at the next release as a cell out of order or missing. It can also show as `in_ready` taking the wrong level on the cycle the store fills. The bench logs the edge of every handshake and compares the spacing against interval arithmetic that it derives from the timer's reset phase.

// File: rtl/cell_pacer.sv
module cell_pacer #(
  parameter int CELL_W     = 32,
  parameter int DEPTH      = 16,
  parameter int PACE       = 64,
  parameter int MAX_TOKENS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CELL_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CELL_W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (PACE > 1) ? $clog2(PACE) : 1;
  localparam int TW = $clog2(MAX_TOKENS + 1);

  logic [CELL_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic [PW-1:0]     pace_cnt;
  logic [TW-1:0]     tok_cnt;
  logic              tick, push, pop;

  assign tick      = (pace_cnt == PW'(PACE - 1));
  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0) && (tok_cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) pace_cnt <= '0;
    else        pace_cnt <= tick ? '0 : pace_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_cnt <= '0;
    end else begin
      case ({tick, pop})
        2'b10:   if (tok_cnt != TW'(MAX_TOKENS)) tok_cnt <= tok_cnt + 1'b1;
        2'b01:   tok_cnt <= tok_cnt - 1'b1;
        default: tok_cnt <= tok_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

module cell_pacer_chk #(
  parameter int CELL_W     = 32,
  parameter int DEPTH      = 16,
  parameter int MAX_TOKENS = 8,
  parameter int CW         = 5,
  parameter int TW         = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CELL_W-1:0] out_data,
  input logic [CW-1:0]     count,
  input logic [TW-1:0]     tokens,
  input logic              tick
);
  assert_reset_empty_R1: assert property (@(posedge clk) $rose(rst_n) |-> (tokens == '0) && !out_valid);
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n) (count == CW'(DEPTH)) |-> !in_ready);
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  assert_valid_needs_token_R5: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (tokens != '0) && (count != '0));
  assert_token_cap_R6: assert property (@(posedge clk) disable iff (!rst_n) tokens <= TW'(MAX_TOKENS));
  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  assert_spend_one_R7: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && !tick) |=> tokens == $past(tokens) - 1'b1);
  assert_earn_spend_R8: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && tick) |=> $stable(tokens));
endmodule

bind cell_pacer cell_pacer_chk #(
  .CELL_W(CELL_W), .DEPTH(DEPTH), .MAX_TOKENS(MAX_TOKENS), .CW(CW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .count(count), .tokens(tok_cnt),
  .tick(tick)
);

// File: tb/tb_cell_pacer.sv
`timescale 1ns/1ps
module tb_cell_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int DEP  = 4;
  localparam int PACE = 8;
  localparam int MAXT = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [W-1:0] in_data = '0, out_data;

  int total = 0, bad = 0, ecnt = 0;
  logic [W-1:0] exp_q[$];
  int pops[$];

  cell_pacer #(.CELL_W(W), .DEPTH(DEP), .PACE(PACE), .MAX_TOKENS(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      pops.push_back(ecnt + 1);
      if (exp_q.size() == 0) check(0, "R2", "unexpected cell", int'(out_data), -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R2", "cell order", int'(out_data), int'(e));
      end
    end
  end

  task automatic send(input logic [W-1:0] d);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_pops(input int n);
    while (pops.size() < n) begin @(negedge clk); #2; end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, pe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    #1;
    // R1: first release waits one full interval
    send(16'hB000);
    wait_pops(1);
    check(pops[0] == PACE + 1, "R1", "first release edge", pops[0], PACE + 1);

    // R6/R3/R7: stall output, let tokens reach cap, fill store
    out_ready = 0;
    repeat (4 * PACE) @(negedge clk);
    for (int i = 0; i < DEP; i++) send(16'hC000 + 16'(i));
    #1;
    check(in_ready == 0, "R3", "in_ready when full", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      check(out_valid == 1, "R7", "valid held in stall", out_valid, 1);
      check(out_data == 16'hC000, "R7", "data held in stall", int'(out_data), 'hC000);
      @(negedge clk); #1;
    end
    fork send(16'hC004); join_none
    do @(negedge clk); while (ecnt % PACE != 1);
    e = ecnt;
    pops.delete();
    out_ready = 1;
    wait_pops(5);
    check(pops[0] == e + 1, "R6", "burst pop 1", pops[0], e + 1);
    check(pops[1] == e + 2, "R6", "burst pop 2", pops[1], e + 2);
    check(pops[2] == e + 3, "R6", "burst pop 3", pops[2], e + 3);
    check(pops[3] == e + PACE, "R6", "pop after cap burst", pops[3], e + PACE);
    check(pops[4] == e + 2 * PACE, "R3", "held cell released", pops[4], e + 2 * PACE);

    // R4: steady pacing under backlog
    pops.delete();
    for (int i = 0; i < 6; i++) send(16'hD000 + 16'(i));
    wait_pops(6);
    for (int i = 1; i < 6; i++)
      check(pops[i] - pops[i-1] == PACE, "R4", "release spacing", pops[i] - pops[i-1], PACE);

    // R8: earn and spend on the same edge
    pops.delete();
    for (int i = 0; i < 3; i++) send(16'hE000 + 16'(i));
    wait_pops(1);
    pe = pops[0];
    out_ready = 0;
    repeat (2 * PACE - 2) @(negedge clk);
    out_ready = 1;
    wait_pops(3);
    check(pops[1] == pe + 2 * PACE - 1, "R8", "pop on tick edge", pops[1], pe + 2 * PACE - 1);
    check(pops[2] == pe + 2 * PACE, "R8", "token kept after tick+pop", pops[2], pe + 2 * PACE);
    #1;
    check(exp_q.size() == 0, "R2", "cells remaining", exp_q.size(), 0);
    check(out_valid == 0, "R5", "valid with empty store", out_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule